// File: doc/BRIEF.md
# Four-Bit Port I/O Expander

This block adds four 4-bit peripheral ports to a controller that has only a narrow nibble bus and a strobe. Each transfer uses two edges of the strobe. On the falling edge the controller presents a control nibble that names a port and an operation. On the rising edge the operation completes. A write puts the bus nibble into the port latch, either directly or merged with the latch by OR or AND. A read returns the port pins on the bus while the strobe is low.

The strobe and the active-low select pass through a two-flop synchronizer into one free-running clock, so everything inside runs in a single clock domain. Each port latch drives its pins after a write and releases them after a read. Every bidirectional pin is split into input, output and output-enable signals, so pad buffers stay outside the block. The controller must hold the bus nibble stable for at least three clocks after each strobe edge.

Top module: `nibx_expander`

## Requirements
- R1: After reset every port latch holds 0000, every port output enable is low, and the bus output enable is low.
- R2: Control nibble: bits [1:0] select port index 0 to 3, and bits [3:2] select the operation: 00 read, 01 direct write, 10 OR-merge, 11 AND-merge.
- R3: A direct write loads the bus nibble into the selected latch and sets that port's output enables, within three clocks of the strobe rising edge.
- R4: An OR-merge write sets the selected latch to the old latch value ORed with the bus nibble, and the port is then driven.
- R5: An AND-merge write sets the selected latch to the old latch value ANDed with the bus nibble, and the port is then driven.
- R6: Between the falling and rising strobe edges of a read, the bus output enables are high and the bus output carries the selected port's input pins.
- R7: A read clears the selected port's output enables and leaves its latch unchanged.
- R8: The bus output enable is low during every write and after the rising edge that ends a read.
- R9: While the synchronized select is high (deselected), no port output, port enable, bus enable or latched control changes, even if the strobe toggles.
- R10: A transfer changes at most the selected port. All other latches and enables keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Transfer strobe: fall = control, rise = data |
| sel_n_i | input | 1 | Active-low select |
| bus_i | input | 4 | System nibble bus, pin input value |
| bus_o | output | 4 | System nibble bus, output value |
| bus_oe | output | 4 | System nibble bus, per-pin output enable |
| port_i | input | 16 | Peripheral pins in, port k at bits [4k+3:4k] |
| port_o | output | 16 | Peripheral latch values, same layout |
| port_oe | output | 16 | Peripheral per-pin output enables, same layout |

## Verification
If the latched control is wrong, the next rising edge updates the wrong port or uses the wrong merge. This shows on port_o and port_oe within three clocks of that edge. If the data-phase flag is wrong, the bus enable is asserted during a write or stays high after a read ends, and this can be seen on the very next sampled clock. A leak through the select gate changes a latch while the block is deselected. The bench catches each of these by comparing all sixteen latch and enable bits after every transfer, not only the addressed port.

// File: rtl/nibx_pkg.sv
package nibx_pkg;
    parameter int unsigned NIB_W  = 4;
    parameter int unsigned PORT_N = 4;
    localparam int unsigned SEL_W = $clog2(PORT_N);

    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_OR  = 2'b10,
        OP_AND = 2'b11
    } op_e;

    // control nibble: operation in the upper bits, port index in the lower
    typedef struct packed {
        op_e              op;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    function automatic logic [NIB_W-1:0] merge(op_e op, logic [NIB_W-1:0] old_v,
                                               logic [NIB_W-1:0] new_v);
        case (op)
            OP_OR:   return old_v | new_v;
            OP_AND:  return old_v & new_v;
            default: return new_v;
        endcase
    endfunction
endpackage

// File: rtl/nibx_sync.sv
module nibx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic sel_n_i,
    output logic fall,
    output logic rise,
    output logic cs_off
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] strb_pipe;
    logic [STAGES-1:0] sel_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_pipe <= '1;
            sel_pipe  <= '1;
        end else begin
            strb_pipe <= {strb_pipe[DEPTH-2:0], strobe_i};
            sel_pipe  <= {sel_pipe[STAGES-2:0], sel_n_i};
        end
    end

    assign fall   =  strb_pipe[DEPTH-1] & ~strb_pipe[DEPTH-2];
    assign rise   = ~strb_pipe[DEPTH-1] &  strb_pipe[DEPTH-2];
    assign cs_off =  sel_pipe[STAGES-1];
endmodule

// File: rtl/nibx_ctrl.sv
module nibx_ctrl
    import nibx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic             rise,
    input  logic             cs_off,
    input  logic [NIB_W-1:0] bus_i,
    output ctl_t             ctl_q,
    output logic             rd_phase,
    output logic             commit
);
    logic dphase;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            dphase <= 1'b0;
        end else if (!cs_off) begin
            if (fall) begin
                ctl_q  <= ctl_t'(bus_i);
                dphase <= 1'b1;
            end else if (rise) begin
                dphase <= 1'b0;
            end
        end
    end

    assign commit   = rise & ~cs_off & dphase;
    assign rd_phase = dphase & (ctl_q.op == OP_RD);
endmodule

// File: rtl/nibx_port.sv
module nibx_port
    import nibx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  op_e              op,
    input  logic [NIB_W-1:0] bus_i,
    output logic [NIB_W-1:0] lat_q,
    output logic             drive_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q   <= '0;
            drive_q <= 1'b0;
        end else if (hit) begin
            if (op == OP_RD) begin
                drive_q <= 1'b0;
            end else begin
                lat_q   <= merge(op, lat_q, bus_i);
                drive_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/nibx_expander.sv
module nibx_expander
    import nibx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    strobe_i,
    input  logic                    sel_n_i,
    input  logic [NIB_W-1:0]        bus_i,
    output logic [NIB_W-1:0]        bus_o,
    output logic [NIB_W-1:0]        bus_oe,
    input  logic [PORT_N*NIB_W-1:0] port_i,
    output logic [PORT_N*NIB_W-1:0] port_o,
    output logic [PORT_N*NIB_W-1:0] port_oe
);
    logic s_fall, s_rise, s_csoff, s_commit, rd_phase;
    ctl_t ctl_q;

    nibx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .strobe_i(strobe_i), .sel_n_i(sel_n_i),
        .fall(s_fall), .rise(s_rise), .cs_off(s_csoff)
    );

    nibx_ctrl u_ctrl (
        .clk(clk), .rst(rst), .fall(s_fall), .rise(s_rise), .cs_off(s_csoff),
        .bus_i(bus_i), .ctl_q(ctl_q), .rd_phase(rd_phase), .commit(s_commit)
    );

    for (genvar g = 0; g < PORT_N; g++) begin : g_port
        logic [NIB_W-1:0] lat;
        logic             drv;
        nibx_port u_port (
            .clk(clk), .rst(rst),
            .hit(s_commit && (ctl_q.sel == SEL_W'(g))),
            .op(ctl_q.op), .bus_i(bus_i), .lat_q(lat), .drive_q(drv)
        );
        assign port_o[g*NIB_W +: NIB_W]  = lat;
        assign port_oe[g*NIB_W +: NIB_W] = {NIB_W{drv}};
    end

    assign bus_o  = port_i[ctl_q.sel*NIB_W +: NIB_W];
    assign bus_oe = {NIB_W{rd_phase}};
endmodule

// File: rtl/nibx_chk.sv
module nibx_chk
    import nibx_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    s_csoff,
    input logic                    s_commit,
    input ctl_t                    ctl_q,
    input logic [NIB_W-1:0]        bus_i,
    input logic [NIB_W-1:0]        bus_oe,
    input logic [PORT_N*NIB_W-1:0] port_o,
    input logic [PORT_N*NIB_W-1:0] port_oe
);
    logic             com_d;
    op_e              op_d;
    logic [SEL_W-1:0] sel_d;
    logic [NIB_W-1:0] bus_d, old_d;
    logic [PORT_N*NIB_W-1:0] po_d, poe_d;
    logic [PORT_N-1:0] chg;

    always_ff @(posedge clk) begin
        if (rst) com_d <= 1'b0;
        else     com_d <= s_commit;
        op_d  <= ctl_q.op;
        sel_d <= ctl_q.sel;
        bus_d <= bus_i;
        old_d <= port_o[ctl_q.sel*NIB_W +: NIB_W];
        po_d  <= port_o;
        poe_d <= port_oe;
    end

    for (genvar g = 0; g < PORT_N; g++) begin : g_chg
        assign chg[g] = (port_o[g*NIB_W +: NIB_W] != po_d[g*NIB_W +: NIB_W]) ||
                        (port_oe[g*NIB_W +: NIB_W] != poe_d[g*NIB_W +: NIB_W]);
    end

    // R9
    deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s_csoff |=> $stable(port_o) && $stable(port_oe) && $stable(bus_oe) && $stable(ctl_q));
    // R8
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        s_commit |=> bus_oe == '0);
    // R6
    bus_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        (|bus_oe) |-> ctl_q.op == OP_RD);
    // R3
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        (com_d && op_d == OP_WR) |-> (port_o[sel_d*NIB_W +: NIB_W] == bus_d) &&
                                     (&port_oe[sel_d*NIB_W +: NIB_W]));
    // R4
    or_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (com_d && op_d == OP_OR) |-> port_o[sel_d*NIB_W +: NIB_W] == (old_d | bus_d));
    // R5
    and_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (com_d && op_d == OP_AND) |-> port_o[sel_d*NIB_W +: NIB_W] == (old_d & bus_d));
    // R7
    read_float_chk: assert property (@(posedge clk) disable iff (rst)
        (com_d && op_d == OP_RD) |-> (port_oe[sel_d*NIB_W +: NIB_W] == '0) &&
                                     (port_o[sel_d*NIB_W +: NIB_W] == old_d));
    // R10
    single_port_chk: assert property (@(posedge clk) disable iff (rst)
        !com_d |-> $countones(chg) == 0);
    // R10
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        com_d |-> $countones(chg) <= 1);
endmodule

bind nibx_expander nibx_chk u_chk (
    .clk(clk), .rst(rst), .s_csoff(s_csoff), .s_commit(s_commit), .ctl_q(ctl_q),
    .bus_i(bus_i), .bus_oe(bus_oe), .port_o(port_o), .port_oe(port_oe)
);

// File: tb/tb_nibx_expander.sv
module tb_nibx_expander;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe_i = 1'b1;
    logic        sel_n_i = 1'b1;
    logic [3:0]  bus_i = '0;
    logic [3:0]  bus_o, bus_oe;
    logic [15:0] port_i = '0;
    logic [15:0] port_o, port_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [3:0] exp_lat [4];
    logic       exp_drv [4];
    logic [3:0] ph_bus, ph_oe;

    always #10 clk = ~clk;

    nibx_expander dut (
        .clk(clk), .rst(rst), .strobe_i(strobe_i), .sel_n_i(sel_n_i),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .port_i(port_i), .port_o(port_o), .port_oe(port_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_o();
        logic [15:0] v;
        for (int k = 0; k < 4; k++) v[k*4 +: 4] = exp_lat[k];
        return v;
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] v;
        for (int k = 0; k < 4; k++) v[k*4 +: 4] = {4{exp_drv[k]}};
        return v;
    endfunction

    task automatic chk_ports(input string req);
        chk(req, "port_o", port_o, exp_o());
        chk(req, "port_oe", port_oe, exp_oe());
    endtask

    // one complete transfer; ctl = {op[1:0], sel[1:0]}
    task automatic xact(input logic [3:0] ctl, input logic [3:0] data, input logic csn);
        sel_n_i = csn;
        step(3);
        bus_i = ctl;
        step(1);
        strobe_i = 1'b0;
        step(5);
        ph_oe  = bus_oe;
        ph_bus = bus_o;
        bus_i  = data;
        step(2);
        strobe_i = 1'b1;
        step(5);
        sel_n_i = 1'b0;
        step(3);
        if (!csn) begin
            case (ctl[3:2])
                2'b00: exp_drv[ctl[1:0]] = 1'b0;
                2'b01: begin exp_lat[ctl[1:0]] = data; exp_drv[ctl[1:0]] = 1'b1; end
                2'b10: begin exp_lat[ctl[1:0]] |= data; exp_drv[ctl[1:0]] = 1'b1; end
                default: begin exp_lat[ctl[1:0]] &= data; exp_drv[ctl[1:0]] = 1'b1; end
            endcase
        end
    endtask

    task automatic t_reset();
        chk("R1", "port_o", port_o, 16'h0000);
        chk("R1", "port_oe", port_oe, 16'h0000);
        chk("R1", "bus_oe", {12'h0, bus_oe}, 16'h0000);
    endtask

    task automatic t_each_port();
        for (int p = 0; p < 4; p++) begin
            xact({2'b01, 2'(p)}, 4'(p + 9), 1'b0);
            chk_ports("R2");
            chk("R8", "bus_oe during write", {12'h0, ph_oe}, 16'h0000);
        end
        xact(4'b0110, 4'h3, 1'b0);
        chk_ports("R3");
        chk_ports("R10");
    endtask

    task automatic t_merge();
        xact(4'b1000, 4'h6, 1'b0);
        chk("R4", "port0 OR", {12'h0, port_o[3:0]}, 16'h000F);
        chk_ports("R4");
        xact(4'b1111, 4'h5, 1'b0);
        chk("R5", "port3 AND", {12'h0, port_o[15:12]}, 16'h0004);
        chk_ports("R5");
    endtask

    task automatic t_read();
        port_i = 16'h7A5C;
        xact(4'b0010, 4'h0, 1'b0);
        chk("R6", "bus_oe in read", {12'h0, ph_oe}, 16'h000F);
        chk("R6", "bus_o in read", {12'h0, ph_bus}, 16'h000A);
        chk("R8", "bus_oe after read", {12'h0, bus_oe}, 16'h0000);
        chk_ports("R7");
        xact(4'b0000, 4'h0, 1'b0);
        chk("R6", "bus_o port0", {12'h0, ph_bus}, 16'h000C);
        chk("R7", "port0 latch kept", {12'h0, port_o[3:0]}, 16'h000F);
        chk_ports("R7");
    endtask

    task automatic t_deselect();
        xact(4'b0101, 4'hE, 1'b1);
        chk_ports("R9");
        xact(4'b0001, 4'h0, 1'b1);
        chk("R9", "bus_oe deselected", {12'h0, ph_oe}, 16'h0000);
        chk_ports("R9");
        xact(4'b0101, 4'h2, 1'b0);
        chk_ports("R10");
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin exp_lat[k] = '0; exp_drv[k] = 1'b0; end
        step(4);
        rst = 1'b0;
        step(2);
        t_reset();
        t_each_port();
        t_merge();
        t_read();
        t_deselect();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule